// File: doc/BRIEF.md
# Serial Audio Slot Receiver

This block is a slave-mode receiver for a serial audio link. It takes an external bit clock, a frame clock and one serial data line, and oversamples all three with the system clock. It finds the sampling edge of the bit clock and the start of each frame. It turns each time slot of the stream into a signed 24-bit parallel word, MSB first. Each word comes out with a one-cycle valid strobe and the number of the slot it came from.

Static configuration inputs select the frame size (2, 4, 8 or 16 slots of 32 bit clocks each), the bit clock edge, the frame clock edge, the MSB delay and the word length. The frame clock may be a 50% square wave or a pulse one bit wide; in both cases only its leading edge is used. When the bit count between two frame starts does not match the configured frame size, a pulse flags a framing error and the receiver realigns on the new start. Tying every configuration input to zero selects the common two-channel format: falling frame clock edge, sampling on the rising bit clock, one bit of MSB delay and 24-bit words.

Top module: `audRx`

## Requirements
- R1: The three serial inputs pass through a two-flop synchroniser. Data is sampled on the rising edge of `bclkIn` when `cfgBclkPol`=0 and on the falling edge when `cfgBclkPol`=1.
- R2: A frame starts at the sampling edge where the frame clock is first seen at its active level: low (falling edge) when `cfgLrPol`=0, high (rising edge) when `cfgLrPol`=1. This works the same for a 50% square wave and for a one-bit pulse. The bit sampled at that edge is frame position 0.
- R3: Every slot is 32 bit positions long. Slot k covers positions 32k to 32k+31, so slot 0 (left) comes before slot 1 (right), and in an n-slot frame slots n/2 to n-1 fill the second half.
- R4: `cfgChanMode` 0/1/2/3 selects 2/4/8/16 slots per frame (64/128/256/512 bit clocks), and `sampleSlot` is always below the slot count.
- R5: `cfgMsbDelay` sets the slot position of the MSB: code 0 → 1, code 1 → 0, code 2 → 8, code 3 → 12, code 4 → 16. Codes 5 to 7 act as code 0.
- R6: `cfgWordLen` 0/1/2 selects a 24/20/16-bit word (code 3 acts as 0). The word sits MSB-aligned at bit 23 of `sampleData`, and unused LSBs are zero.
- R7: Bits after the word length, and word bits that would fall past the end of their slot, are dropped without any error indication.
- R8: `sampleValid` pulses for one cycle a few system clocks after the last bit (position 31) of each slot is sampled, with `sampleData` and `sampleSlot` valid in that cycle.
- R9: Once aligned, `frameErr` pulses for one cycle at any frame start whose previous frame length differs from the configured length. Counting restarts at position 0. Positions at or beyond the configured frame length produce no sample.
- R10: After reset all outputs are zero, and no sample or error appears before the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rstN | input | 1 | Asynchronous active-low reset |
| bclkIn | input | 1 | External bit clock |
| lrclkIn | input | 1 | External frame clock (square wave or pulse) |
| sdataIn | input | 1 | Serial data, two's complement, MSB first |
| cfgChanMode | input | 2 | Slots per frame: 0=2, 1=4, 2=8, 3=16 |
| cfgBclkPol | input | 1 | 0: sample on rising bit clock, 1: on falling |
| cfgLrPol | input | 1 | 0: frame starts on falling frame clock, 1: on rising |
| cfgMsbDelay | input | 3 | MSB delay code (see R5) |
| cfgWordLen | input | 2 | Word length code (see R6) |
| sampleData | output | 24 | Received word, MSB at bit 23 |
| sampleValid | output | 1 | One-cycle strobe per received slot |
| sampleSlot | output | 4 | Slot number of the current word |
| frameErr | output | 1 | One-cycle framing error strobe |

## Verification
A position counter that is off by one shifts every later word by one bit. That shows at the very next strobe as a doubled or halved data value. It also makes the error strobe fire at the next frame start, one frame later at most. A wrong edge or polarity choice scrambles the first word of the first frame. A slot or length decode fault shows as a missing, extra or misnumbered strobe within the same frame. The end-of-run count of words and errors catches any strobe that went missing.

// File: rtl/audRxPkg.sv
package audRxPkg;
  localparam int SLOT_BITS = 32;
  localparam int SAMPLE_W  = 24;
  localparam int MAX_SLOTS = 16;
  localparam int POS_W     = $clog2(SLOT_BITS * MAX_SLOTS) + 1;
  localparam int SLOTIDX_W = $clog2(MAX_SLOTS);
  localparam int INSLOT_W  = $clog2(SLOT_BITS);
  localparam int BITPOS_W  = $clog2(SAMPLE_W);

  // strobes from control to datapath, valid in the cycle of a sampling edge
  typedef struct packed {
    logic                 tick;
    logic                 clear;
    logic                 capture;
    logic [BITPOS_W-1:0]  bitPos;
    logic                 bitVal;
    logic                 emit;
    logic [SLOTIDX_W-1:0] slot;
  } rxStrobeT;
endpackage

// File: rtl/audRxSync.sv
module audRxSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/audRxCtrl.sv
module audRxCtrl
  import audRxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclkS,
  input  logic       lrS,
  input  logic       dataS,
  input  logic [1:0] cfgChanMode,
  input  logic       cfgBclkPol,
  input  logic       cfgLrPol,
  input  logic [2:0] cfgMsbDelay,
  input  logic [1:0] cfgWordLen,
  output rxStrobeT   strb,
  output logic       frameErr
);
  localparam int OFS_W = INSLOT_W + 1;

  logic bclkE, bclkPrev, tick;
  logic lrE, lrPrev, startNow;
  logic synced, syncNow;
  logic [POS_W-1:0] posCnt, posNext, frameLen;
  logic [OFS_W-1:0] delayBits, wordBits, inSlotW, offset;
  logic [INSLOT_W-1:0] inSlot;

  assign bclkE    = bclkS ^ cfgBclkPol;
  assign tick     = bclkE & ~bclkPrev;
  assign lrE      = lrS ^ ~cfgLrPol;
  assign startNow = tick & lrE & ~lrPrev;
  assign syncNow  = synced | startNow;
  assign frameLen = POS_W'(2 * SLOT_BITS) << cfgChanMode;

  always_comb begin
    case (cfgMsbDelay)
      3'd1:    delayBits = OFS_W'(0);
      3'd2:    delayBits = OFS_W'(8);
      3'd3:    delayBits = OFS_W'(12);
      3'd4:    delayBits = OFS_W'(16);
      default: delayBits = OFS_W'(1);
    endcase
    case (cfgWordLen)
      2'd1:    wordBits = OFS_W'(20);
      2'd2:    wordBits = OFS_W'(16);
      default: wordBits = OFS_W'(SAMPLE_W);
    endcase
  end

  always_comb begin
    if (startNow)     posNext = '0;
    else if (&posCnt) posNext = posCnt;
    else              posNext = posCnt + 1'b1;
  end

  assign inSlot  = posNext[INSLOT_W-1:0];
  assign inSlotW = {1'b0, inSlot};
  assign offset  = inSlotW - delayBits;

  always_comb begin
    strb.tick    = tick;
    strb.clear   = tick & (inSlot == '0);
    strb.capture = tick & syncNow & (inSlotW >= delayBits) & (offset < wordBits);
    strb.bitPos  = BITPOS_W'(SAMPLE_W - 1) - offset[BITPOS_W-1:0];
    strb.bitVal  = dataS;
    strb.emit    = tick & syncNow & (&inSlot) & (posNext < frameLen);
    strb.slot    = posNext[INSLOT_W +: SLOTIDX_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPrev <= 1'b1;
      lrPrev   <= 1'b1;
      posCnt   <= '1;
      synced   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      bclkPrev <= bclkE;
      frameErr <= startNow & synced & (posCnt != frameLen - 1'b1);
      if (tick) begin
        lrPrev <= lrE;
        posCnt <= posNext;
      end
      if (startNow) synced <= 1'b1;
    end
  end
endmodule

// File: rtl/audRxData.sv
module audRxData
  import audRxPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobeT             strb,
  output logic [SAMPLE_W-1:0]  sampleData,
  output logic                 sampleValid,
  output logic [SLOTIDX_W-1:0] sampleSlot
);
  logic [SAMPLE_W-1:0] word, wordNext;

  always_comb begin
    wordNext = strb.clear ? '0 : word;
    if (strb.capture) wordNext[strb.bitPos] = strb.bitVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word        <= '0;
      sampleData  <= '0;
      sampleValid <= 1'b0;
      sampleSlot  <= '0;
    end else begin
      sampleValid <= strb.emit;
      if (strb.tick) word <= wordNext;
      if (strb.emit) begin
        sampleData <= wordNext;
        sampleSlot <= strb.slot;
      end
    end
  end
endmodule

// File: rtl/audRx.sv
module audRx
  import audRxPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bclkIn,
  input  logic                 lrclkIn,
  input  logic                 sdataIn,
  input  logic [1:0]           cfgChanMode,
  input  logic                 cfgBclkPol,
  input  logic                 cfgLrPol,
  input  logic [2:0]           cfgMsbDelay,
  input  logic [1:0]           cfgWordLen,
  output logic [SAMPLE_W-1:0]  sampleData,
  output logic                 sampleValid,
  output logic [SLOTIDX_W-1:0] sampleSlot,
  output logic                 frameErr
);
  logic [2:0] syncQ;
  rxStrobeT   strb;

  audRxSync #(.WIDTH(3), .STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .d({bclkIn, lrclkIn, sdataIn}), .q(syncQ)
  );

  audRxCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .bclkS(syncQ[2]), .lrS(syncQ[1]), .dataS(syncQ[0]),
    .cfgChanMode(cfgChanMode), .cfgBclkPol(cfgBclkPol), .cfgLrPol(cfgLrPol),
    .cfgMsbDelay(cfgMsbDelay), .cfgWordLen(cfgWordLen),
    .strb(strb), .frameErr(frameErr)
  );

  audRxData uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .sampleData(sampleData), .sampleValid(sampleValid), .sampleSlot(sampleSlot)
  );
endmodule

// File: rtl/audRxChk.sv
module audRxChk
  import audRxPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           cfgChanMode,
  input logic [2:0]           cfgMsbDelay,
  input logic [1:0]           cfgWordLen,
  input logic [SAMPLE_W-1:0]  sampleData,
  input logic                 sampleValid,
  input logic [SLOTIDX_W-1:0] sampleSlot,
  input logic                 frameErr
);
  logic [SLOTIDX_W:0]   nCh;
  logic [SLOTIDX_W-1:0] lastSlot;
  logic                 seenAny;

  assign nCh = (SLOTIDX_W + 1)'(2 << cfgChanMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSlot <= '0;
      seenAny  <= 1'b0;
    end else if (sampleValid) begin
      lastSlot <= sampleSlot;
      seenAny  <= 1'b1;
    end
  end

  // R4: slot number stays inside the configured frame
  a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> ({1'b0, sampleSlot} < nCh));
  // R3: slots leave in ascending order, or restart at 0
  a_r3_slot_order: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && seenAny && sampleSlot != '0) |-> (sampleSlot == lastSlot + 1'b1));
  // R8: valid is a single-cycle strobe
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
  // R9: error strobe is single-cycle and never shares a cycle with a word
  a_r9_err_single: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
  a_r9_err_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(frameErr && sampleValid));
  // R6: unused LSBs are zero-filled
  a_r6_zero_fill16: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && cfgWordLen == 2'd2) |-> (sampleData[7:0] == '0));
  a_r6_zero_fill20: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && cfgWordLen == 2'd1) |-> (sampleData[3:0] == '0));
  // R7: with a 16-bit MSB delay, no bit past the slot end is kept
  a_r7_slot_clip: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && cfgMsbDelay == 3'd4) |-> (sampleData[7:0] == '0));
endmodule

bind audRx audRxChk uChk (
  .clk(clk), .rstN(rstN), .cfgChanMode(cfgChanMode), .cfgMsbDelay(cfgMsbDelay),
  .cfgWordLen(cfgWordLen), .sampleData(sampleData), .sampleValid(sampleValid),
  .sampleSlot(sampleSlot), .frameErr(frameErr)
);

// File: tb/tb_audRx.sv
`timescale 1ns/1ps
module tb_audRx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclkIn = 1'b0, lrclkIn = 1'b1, sdataIn = 1'b0;
  logic [1:0] cfgChanMode = '0;
  logic cfgBclkPol = 1'b0, cfgLrPol = 1'b0;
  logic [2:0] cfgMsbDelay = '0;
  logic [1:0] cfgWordLen = '0;
  logic [23:0] sampleData;
  logic sampleValid, frameErr;
  logic [3:0] sampleSlot;

  audRx dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int wrIdx = 0, rdIdx = 0, expErr = 0, errSeen = 0, prevLen = -1;
  int delayV, wordV, nCh, fLen;
  bit pulseMode;
  string tagS = "R10";
  bit stream [0:511];
  logic [23:0] expData [0:255];
  int expSlot [0:255];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int delayOf(int c);
    case (c)
      1: return 0;
      2: return 8;
      3: return 12;
      4: return 16;
      default: return 1;
    endcase
  endfunction

  function automatic int wlenOf(int c);
    case (c)
      1: return 20;
      2: return 16;
      default: return 24;
    endcase
  endfunction

  // R5 R6 R7: expected word of slot s from the bits on the line
  function automatic logic [23:0] expWord(int s);
    logic [23:0] w = '0;
    for (int o = 0; o < wordV; o++)
      if (delayV + o < 32) w[23 - o] = stream[s * 32 + delayV + o];
    return w;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid) begin
        if (rdIdx >= wrIdx) check(1'b0, tagS, "unexpected sample slot", sampleSlot, 0);
        else begin
          check(sampleData == expData[rdIdx], tagS, "R8 data", sampleData, expData[rdIdx]);
          check(sampleSlot == expSlot[rdIdx][3:0], tagS, "R3 slot", sampleSlot, expSlot[rdIdx]);
          rdIdx++;
        end
      end
      if (frameErr) errSeen++;
    end
  end

  task automatic sendBit(bit lrA, bit d);
    bclkIn  = cfgBclkPol;
    lrclkIn = lrA ^ ~cfgLrPol;
    sdataIn = d;
    repeat (4) @(negedge clk);
    bclkIn = ~cfgBclkPol;
    repeat (4) @(negedge clk);
  endtask

  task automatic startScen(int mode, bit bp, bit lp, int dc, int wc, bit pm, string tag);
    @(negedge clk);
    rstN = 1'b0;
    cfgChanMode = 2'(mode); cfgBclkPol = bp; cfgLrPol = lp;
    cfgMsbDelay = 3'(dc); cfgWordLen = 2'(wc);
    bclkIn = bp; lrclkIn = ~lp; sdataIn = 1'b0;
    delayV = delayOf(dc); wordV = wlenOf(wc);
    nCh = 2 << mode; fLen = 64 << mode; pulseMode = pm;
    tagS = tag;
    repeat (4) @(negedge clk);
    wrIdx = 0; rdIdx = 0; expErr = 0; errSeen = 0; prevLen = -1;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sampleValid == 1'b0, "R10", "reset valid", sampleValid, 0);
    check(frameErr == 1'b0, "R10", "reset error", frameErr, 0);
    check(sampleData == '0, "R10", "reset data", sampleData, 0);
    for (int i = 0; i < 3; i++) sendBit(1'b0, 1'($urandom % 2));
  endtask

  task automatic sendFrame(int len);
    int hi;
    if (prevLen >= 0 && prevLen != fLen) expErr++;
    prevLen = len;
    hi = (fLen / 2 < len / 2) ? fLen / 2 : len / 2;
    for (int p = 0; p < len; p++) stream[p] = 1'($urandom % 2);
    for (int s = 0; s < nCh; s++)
      if (s * 32 + 31 < len) begin
        expData[wrIdx] = expWord(s);
        expSlot[wrIdx] = s;
        wrIdx++;
      end
    for (int p = 0; p < len; p++)
      sendBit(pulseMode ? (p == 0) : (p < hi), stream[p]);
  endtask

  task automatic endScen();
    bclkIn = cfgBclkPol;
    repeat (20) @(negedge clk);
    check(rdIdx == wrIdx, tagS, "R4 sample count", rdIdx, wrIdx);
    check(errSeen == expErr, tagS, "R9 error count", errSeen, expErr);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R10 R2 R3: all-zero config, square frame clock
    startScen(0, 0, 0, 0, 0, 0, "R10 R2 R3");
    repeat (4) sendFrame(64);
    endScen();
    // R1 R2 R4: falling bit clock, rising frame clock, pulse, 8 slots, no delay
    startScen(2, 1, 1, 1, 0, 1, "R1 R2 R4");
    repeat (3) sendFrame(256);
    endScen();
    // R6 R7: 16 slots, 16-bit words, extra bits dropped
    startScen(3, 0, 0, 0, 2, 1, "R6 R7");
    repeat (2) sendFrame(512);
    endScen();
    // R5: right-justified delays
    startScen(0, 0, 0, 2, 0, 0, "R5 d8");
    repeat (3) sendFrame(64);
    endScen();
    startScen(0, 0, 0, 3, 1, 0, "R5 d12");
    repeat (3) sendFrame(64);
    endScen();
    startScen(0, 1, 0, 4, 2, 0, "R5 d16");
    repeat (3) sendFrame(64);
    endScen();
    // R7: word would run past slot end
    startScen(1, 0, 1, 4, 0, 0, "R7 clip");
    repeat (2) sendFrame(128);
    endScen();
    // R9: short and long frames
    startScen(1, 0, 0, 0, 1, 0, "R9");
    sendFrame(128); sendFrame(40); sendFrame(128); sendFrame(200); sendFrame(128);
    endScen();
    // random configurations
    for (int k = 0; k < 8; k++) begin
      startScen(int'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                int'($urandom % 8), int'($urandom % 4), 1'($urandom % 2), "R1 R5 R6 rand");
      repeat (2) sendFrame(fLen);
      endScen();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule